// File: doc/BRIEF.md
# ADC Control and Result Register Block

This block is the digital side of a 10-bit successive-approximation converter attached to an 8-bit processor bus. Software programs a control/status register to enable the converter, pick a clock divide ratio, choose one-shot or continuous operation and enable the completion interrupt. The block divides the system clock into a converter clock and runs a behavioural conversion engine that finishes a fixed number of converter clocks after start. When it finishes, the engine hands over the value on `sample_in`.

On completion the block latches the result into two read-only byte registers and sets a completion flag. An interrupt request is raised when the flag, the local enable and the global enable are all high. The flag clears when software writes a one to it or when the processor acknowledges the interrupt. Reading the low result byte freezes the result registers until the high byte is read, so that a 10-bit value is always read as one consistent pair, even while continuous conversions are running.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset the control register (offset 0x06), the high result (0x05) and the low result (0x04) all read 0x00, and `irq` is 0.
- R2: Control register bits: 7 = converter enable, 6 = start (reads 1 while a conversion runs), 5 = continuous mode, 4 = completion flag, 3 = interrupt enable, 2..0 = divider select. Bits 7, 5, 3 and 2..0 read back as written. Unmapped offsets read 0x00.
- R3: The divider select maps 0→2, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64, 7→128 system clocks per converter clock. A conversion ends on the 13th converter clock after the start write. With ratio D, the flag is still 0 exactly 12·D cycles after the start write and is 1 exactly 13·D cycles after it.
- R4: A write with bits 7 and 6 both 1 starts a conversion. A start write with bit 7 at 0 starts nothing. In one-shot mode bit 6 returns to 0 when the conversion ends.
- R5: When a conversion ends, the flag sets and the sample is latched. The low result reads result bits 7..0. Bits 1..0 of the high result read result bits 9..8, and its bits 7..2 read 0.
- R6: Writing the control register with bit 4 = 1 clears the flag. Writing it with bit 4 = 0 leaves the flag unchanged.
- R7: A one-cycle pulse on `irq_ack` clears the flag.
- R8: `irq` is 1 exactly when the flag, control bit 3 and `gie` are all 1.
- R9: In continuous mode each ending conversion updates the results and sets the flag, and the next conversion follows with no software action. Writing bit 5 = 0 lets the running conversion finish, and no further conversion starts.
- R10: After a read of the low result, the result registers do not change and the flag does not set until the high result is read. A conversion that ends in this window is dropped.
- R11: Writing bit 7 = 0 aborts any running conversion at once (bit 6 reads 0), resets the divider, and the aborted conversion never sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; drives the result lock |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable from the processor |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| sample_in | input | 10 | Value taken by the conversion engine when a conversion ends |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
One-shot conversions are timed at divider selects 0, 1, 3 and 7. A window of one ratio around the 13th converter clock separates a correct divide ratio and conversion length from an off-by-one count or a wrong table entry. The same conversions use samples with all ones, alternating bits and a sparse pattern, which tell a correct byte split and zeroed upper high bits apart from a shifted or unmasked result. Continuous runs check three cases: successive updates, results held frozen between the low and the high read while the sample changes, and stopping after the current conversion. Abort and interrupt-gating patterns check that the flag and the request respond only to the inputs that should affect them.

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
  parameter int RES_W      = 10,
  parameter int CONV_TICKS = 13,
  parameter logic [7:0] CTRL_ADDR = 8'h06,
  parameter logic [7:0] HIGH_ADDR = 8'h05,
  parameter logic [7:0] LOW_ADDR  = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic             gie,
  input  logic             irq_ack,
  input  logic [RES_W-1:0] sample_in,
  output logic             irq
);
  localparam int STEP_W = $clog2(CONV_TICKS);
  localparam int PRE_W  = 7;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CONV_TICKS - 1);

  logic en, busy, freerun, flag, ie, lock;
  logic [2:0]        psel;
  logic [PRE_W-1:0]  pcnt, pdiv_m1;
  logic [STEP_W-1:0] step;
  logic [RES_W-1:0]  result;
  logic [15:0]       res_ext;

  wire wr_ctrl   = bus_wr && bus_addr == CTRL_ADDR;
  wire rd_low    = bus_rd && bus_addr == LOW_ADDR;
  wire rd_high   = bus_rd && bus_addr == HIGH_ADDR;
  wire abort     = wr_ctrl && !bus_wdata[7];
  wire start_req = wr_ctrl && bus_wdata[7] && bus_wdata[6] && !busy;

  assign pdiv_m1 = (psel == 3'd0) ? PRE_W'(1) : PRE_W'((8'd1 << psel) - 8'd1);
  wire tick = en && pcnt >= pdiv_m1;
  wire done = busy && tick && step == LAST_STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else if (!en || tick) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; freerun <= 1'b0; ie <= 1'b0; psel <= 3'd0;
    end else if (wr_ctrl) begin
      en <= bus_wdata[7]; freerun <= bus_wdata[5];
      ie <= bus_wdata[3]; psel <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; step <= '0;
    end else begin
      if (abort) busy <= 1'b0;
      else if (start_req) busy <= 1'b1;
      else if (done && !freerun) busy <= 1'b0;
      if (abort || start_req || done) step <= '0;
      else if (busy && tick) step <= step + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0; result <= '0; lock <= 1'b0;
    end else begin
      if (done && !lock) begin
        flag   <= 1'b1;
        result <= sample_in;
      end else if (irq_ack || (wr_ctrl && bus_wdata[4])) begin
        flag <= 1'b0;
      end
      if (rd_high) lock <= 1'b0;
      else if (rd_low) lock <= 1'b1;
    end
  end

  assign res_ext = 16'(result);
  assign irq = flag && ie && gie;

  always_comb begin
    case (bus_addr)
      CTRL_ADDR: bus_rdata = {en, busy, freerun, flag, ie, psel};
      HIGH_ADDR: bus_rdata = res_ext[15:8];
      LOW_ADDR:  bus_rdata = res_ext[7:0];
      default:   bus_rdata = 8'h00;
    endcase
  end

  // R5: the flag only rises right after a conversion ended
  a_r5_flag_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy && tick));

  // R10: while locked the result holds
  a_r10_lock_freezes_result: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(result));

  // R11: abort leaves the engine idle
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && step == '0);

  // R3: step counter stays inside one conversion
  a_r3_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST_STEP);

  // R7: acknowledge without a simultaneous completion clears the flag
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !done |=> !flag);
endmodule

// File: tb/adc_ctrl_regs_test.sv
module adc_ctrl_regs_test;
  localparam logic [7:0] CTRL = 8'h06, HIGH = 8'h05, LOW = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0, gie = 1'b0, irq_ack = 1'b0, irq;
  logic [9:0] sample_in = '0;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [9:0] exp_q[$];

  always #2.5 clk = ~clk;

  adc_ctrl_regs uut (.clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd,
    .bus_rdata, .gie, .irq_ack, .sample_in, .irq);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_sample(input logic [9:0] v);
    sample_in = v;
    exp_q.push_back(v);
  endtask

  task automatic mon_result(input string tag);
    logic [7:0] lo, hi;
    logic [9:0] e;
    rd(LOW, lo); rd(HIGH, hi);
    e = exp_q.pop_front();
    chk(lo == e[7:0], {tag, " low byte"}, lo, e[7:0]);
    chk(hi == {6'b0, e[9:8]}, {tag, " high byte"}, hi, {6'b0, e[9:8]});
  endtask

  task automatic wait_flag(input int lim, input string tag);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < lim && !c[4]; i++) rd(CTRL, c);
    chk(c[4], {tag, " flag reached"}, c[4], 1);
  endtask

  task automatic timed_conv(input logic [2:0] ps, input logic [9:0] v);
    int d;
    logic [7:0] c;
    d = (ps == 3'd0) ? 2 : (1 << ps);
    set_sample(v);
    wr(CTRL, 8'h90 | 8'(ps));
    wr(CTRL, 8'hC0 | 8'(ps));
    repeat (12 * d) @(posedge clk);
    @(negedge clk);
    rd(CTRL, c);
    chk(c[4] == 1'b0, "R3 flag low at 12 ratios", c, 0);
    chk(c[6] == 1'b1, "R4 busy during conversion", c, 8'h40);
    repeat (d - 1) @(posedge clk);
    @(negedge clk);
    rd(CTRL, c);
    chk(c == (8'h90 | 8'(ps)), "R3 R4 R5 flag set, busy cleared at 13 ratios", c, 8'h90 | 8'(ps));
    mon_result("R5 result");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, lo, hi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(CTRL, c); chk(c == 8'h00, "R1 ctrl reset", c, 0);
    rd(LOW, c);  chk(c == 8'h00, "R1 low reset", c, 0);
    rd(HIGH, c); chk(c == 8'h00, "R1 high reset", c, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    rd(8'h07, c); chk(c == 8'h00, "R2 unmapped reads zero", c, 0);

    wr(CTRL, 8'h2D);
    rd(CTRL, c); chk(c == 8'h2D, "R2 readback", c, 8'h2D);
    wr(CTRL, 8'h40);
    rd(CTRL, c); chk(c[6] == 1'b0, "R4 start ignored when disabled", c, 0);

    timed_conv(3'd0, 10'h3FF);
    timed_conv(3'd1, 10'h155);
    timed_conv(3'd3, 10'h2AA);
    timed_conv(3'd7, 10'h081);

    wr(CTRL, 8'h87);
    rd(CTRL, c); chk(c[4], "R6 write 0 keeps flag", c, 8'h97);
    chk(irq == 1'b0, "R8 irq off without ie", irq, 0);
    wr(CTRL, 8'h8F);
    chk(irq == 1'b0, "R8 irq off without gie", irq, 0);
    gie = 1'b1; #1;
    chk(irq == 1'b1, "R8 irq on", irq, 1);
    irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
    rd(CTRL, c); chk(c[4] == 1'b0, "R7 ack clears flag", c, 8'h8F);
    chk(irq == 1'b0, "R8 irq drops with flag", irq, 0);
    gie = 1'b0;

    set_sample(10'h123);
    wr(CTRL, 8'hC0);
    wait_flag(60, "R5");
    wr(CTRL, 8'h90);
    rd(CTRL, c); chk(c[4] == 1'b0, "R6 write 1 clears flag", c, 8'h80);
    mon_result("R5 one-shot");

    set_sample(10'h155);
    wr(CTRL, 8'hE0);
    wait_flag(60, "R9 first");
    mon_result("R9 first result");
    set_sample(10'h2AA);
    wr(CTRL, 8'hB0);
    wait_flag(60, "R9 second");
    mon_result("R9 second result");

    rd(LOW, lo);
    sample_in = 10'h3C3;
    wr(CTRL, 8'hB0);
    repeat (80) @(posedge clk);
    @(negedge clk);
    rd(CTRL, c); chk(c[4] == 1'b0, "R10 no flag while locked", c, 8'hE0);
    rd(LOW, lo); chk(lo == 8'hAA, "R10 low frozen", lo, 8'hAA);
    rd(HIGH, hi); chk(hi == 8'h02, "R10 high frozen", hi, 8'h02);
    exp_q.push_back(10'h3C3);
    wait_flag(60, "R10 after unlock");
    mon_result("R10 result after unlock");

    wr(CTRL, 8'h90);
    rd(CTRL, c); chk(c[6] == 1'b1, "R9 current conversion continues", c, 8'hC0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    rd(CTRL, c); chk(c[6] == 1'b0, "R9 stopped after clearing continuous", c, 8'h90);
    wr(CTRL, 8'h90);
    repeat (80) @(posedge clk);
    @(negedge clk);
    rd(CTRL, c); chk(c == 8'h80, "R9 no further conversions", c, 8'h80);

    wr(CTRL, 8'h83);
    wr(CTRL, 8'hC3);
    repeat (50) @(posedge clk);
    @(negedge clk);
    wr(CTRL, 8'h03);
    rd(CTRL, c); chk(c == 8'h03, "R11 abort clears busy", c, 8'h03);
    repeat (200) @(posedge clk);
    @(negedge clk);
    rd(CTRL, c); chk(c[4] == 1'b0, "R11 aborted conversion sets no flag", c, 8'h03);
    rd(LOW, lo); rd(HIGH, hi);
    chk({hi, lo} == 16'h03C3, "R11 result unchanged", {hi, lo}, 16'h03C3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule